// File: doc/BRIEF.md
# Per-Instruction Stride Prefetcher

This block watches the load and store accesses of a core. Each access arrives as a one-cycle event that carries the program counter of the issuing instruction and the data address. The block keeps a small direct-mapped table. A few low program-counter bits select the entry and the upper bits are stored as a tag. Each entry holds the last address seen for that instruction, the last address difference (the stride) and a saturating confidence count. Because every instruction trains its own entry, several array walks that interleave inside one loop are each learned on their own, whatever their strides.

When the stride just computed for an instruction equals the stride stored for it, and that stride is not zero, the block issues a prefetch hint for the current address plus the stride. The hint leaves on a valid/ready output together with the updated confidence. Prefetches are only hints. If the output is still holding an earlier hint that has not been taken, the new hint is discarded and training carries on.

Top module: `stride_pf`

## Requirements
- R1: The entry index is PC[PC_LSB+IDX_W-1:PC_LSB] and the tag is PC[PC_W-1:PC_LSB+IDX_W]; each entry trains only on accesses whose index selects it.
- R2: An access that finds its entry invalid, or valid with a different tag, reinitialises the entry: it stores the tag and the address, sets the stride to zero and the confidence to zero, and issues no prefetch. The same instruction then needs two more accesses with one equal nonzero stride before it prefetches again.
- R3: On a tag hit where (address − stored address) mod 2^ADDR_W equals the stored stride and is nonzero, a prefetch for (address + stride) mod 2^ADDR_W is presented, with pfValid high from the clock edge that samples the access.
- R4: On such a match the entry confidence increments, saturating at 2^CONF_W−1, and pfConf carries the incremented value.
- R5: On a tag hit whose stride differs from the stored one, the confidence decrements (saturating at 0), the new stride and address are recorded, and no prefetch is issued.
- R6: Negative strides, held in two's complement modulo 2^ADDR_W, are learned and prefetched in the downward direction.
- R7: Three instructions whose accesses interleave, each with its own entry, are each trained and prefetched without disturbing one another.
- R8: While pfValid is high and pfReady is low, pfAddr and pfConf hold steady, and a new prefetch produced in that cycle is dropped.
- R9: A repeated identical address (stride zero) never produces a prefetch.
- R10: After a handshake (pfValid and pfReady high), pfValid goes low at the next edge unless a new prefetch is produced in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | Access event present this cycle |
| accPc | input | PC_W | Program counter of the accessing instruction |
| accAddr | input | ADDR_W | Data address of the access |
| pfValid | output | 1 | Prefetch request valid |
| pfReady | input | 1 | Consumer accepts the prefetch request |
| pfAddr | output | ADDR_W | Address to prefetch |
| pfConf | output | CONF_W | Confidence of the entry that issued the request |

## Verification
The bench builds the block with 16-bit program counters and addresses, PC_LSB of 2, a 16-entry table (IDX_W of 4) and 2-bit confidence. With these values, instructions 4 bytes apart fall in neighbouring entries, and 0x10C and 0x14C alias on entry 3 with different tags. The confidence ceiling of 3 is reached after three matches, so saturation and the drop by one after a mismatch both show within a few accesses. Because addresses are only 16 bits wide, the downward stride of −1 is held as 0xFFFF, so its wrap-around arithmetic is exercised.

// File: rtl/stride_pf_pkg.sv
package stride_pf_pkg;

  // Entry lookup results passed from datapath to control
  typedef struct packed {
    logic hit;       // entry valid and tag equal
    logic strideEq;  // new stride equals stored stride
    logic strideNz;  // new stride is nonzero
  } pfStatus_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic alloc;     // reinitialise the selected entry
    logic train;     // update address/stride/confidence of a hit entry
    logic match;     // the training step is a stride match
    logic load;      // capture a new prefetch into the output register
  } pfStrobe_t;

endpackage

// File: rtl/stride_pf_ctrl.sv
module stride_pf_ctrl
  import stride_pf_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      accValid,
  input  logic      pfReady,
  input  pfStatus_t status,
  output pfStrobe_t strobe,
  output logic      pfValid
);

  logic issue;
  logic outFree;

  always_comb begin
    issue        = accValid && status.hit && status.strideEq && status.strideNz;
    outFree      = !pfValid || pfReady;
    strobe.alloc = accValid && !status.hit;
    strobe.train = accValid && status.hit;
    strobe.match = issue;
    strobe.load  = issue && outFree;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pfValid <= 1'b0;
    end else if (strobe.load) begin
      pfValid <= 1'b1;
    end else if (pfReady) begin
      pfValid <= 1'b0;
    end
  end

endmodule

// File: rtl/stride_pf_dpath.sv
module stride_pf_dpath
  import stride_pf_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 6,
  parameter int PC_LSB = 2,
  parameter int CONF_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PC_W-1:0]   accPc,
  input  logic [ADDR_W-1:0] accAddr,
  input  pfStrobe_t         strobe,
  output pfStatus_t         status,
  output logic [ADDR_W-1:0] pfAddr,
  output logic [CONF_W-1:0] pfConf
);

  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_W   = PC_W - PC_LSB - IDX_W;
  localparam logic [CONF_W-1:0] CONF_MAX = {CONF_W{1'b1}};

  logic              vldQ    [ENTRIES];
  logic [TAG_W-1:0]  tagQ    [ENTRIES];
  logic [ADDR_W-1:0] lastAddrQ  [ENTRIES];
  logic [ADDR_W-1:0] lastStrideQ[ENTRIES];
  logic [CONF_W-1:0] confQ   [ENTRIES];

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tagIn;
  logic [ADDR_W-1:0] newStride;
  logic [CONF_W-1:0] confUp;
  logic [CONF_W-1:0] confDn;

  always_comb begin
    idx             = accPc[PC_LSB +: IDX_W];
    tagIn           = accPc[PC_W-1 -: TAG_W];
    newStride       = accAddr - lastAddrQ[idx];
    status.hit      = vldQ[idx] && (tagQ[idx] == tagIn);
    status.strideEq = (newStride == lastStrideQ[idx]);
    status.strideNz = (newStride != '0);
    confUp          = (confQ[idx] == CONF_MAX) ? confQ[idx] : confQ[idx] + 1'b1;
    confDn          = (confQ[idx] == '0) ? confQ[idx] : confQ[idx] - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int e = 0; e < ENTRIES; e++) begin
        vldQ[e]        <= 1'b0;
        tagQ[e]        <= '0;
        lastAddrQ[e]   <= '0;
        lastStrideQ[e] <= '0;
        confQ[e]       <= '0;
      end
    end else if (strobe.alloc) begin
      vldQ[idx]        <= 1'b1;
      tagQ[idx]        <= tagIn;
      lastAddrQ[idx]   <= accAddr;
      lastStrideQ[idx] <= '0;
      confQ[idx]       <= '0;
    end else if (strobe.train) begin
      lastAddrQ[idx] <= accAddr;
      if (strobe.match) begin
        confQ[idx] <= confUp;
      end else begin
        confQ[idx]       <= confDn;
        lastStrideQ[idx] <= newStride;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pfAddr <= '0;
      pfConf <= '0;
    end else if (strobe.load) begin
      pfAddr <= accAddr + newStride;
      pfConf <= confUp;
    end
  end

endmodule

// File: rtl/stride_pf.sv
module stride_pf
  import stride_pf_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 6,
  parameter int PC_LSB = 2,
  parameter int CONF_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic [PC_W-1:0]   accPc,
  input  logic [ADDR_W-1:0] accAddr,
  output logic              pfValid,
  input  logic              pfReady,
  output logic [ADDR_W-1:0] pfAddr,
  output logic [CONF_W-1:0] pfConf
);

  pfStatus_t status;
  pfStrobe_t strobe;

  stride_pf_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .accValid (accValid),
    .pfReady  (pfReady),
    .status   (status),
    .strobe   (strobe),
    .pfValid  (pfValid)
  );

  stride_pf_dpath #(
    .PC_W   (PC_W),
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W),
    .PC_LSB (PC_LSB),
    .CONF_W (CONF_W)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .accPc   (accPc),
    .accAddr (accAddr),
    .strobe  (strobe),
    .status  (status),
    .pfAddr  (pfAddr),
    .pfConf  (pfConf)
  );

endmodule

// File: rtl/stride_pf_chk.sv
module stride_pf_chk #(
  parameter int ADDR_W = 32,
  parameter int CONF_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              accValid,
  input logic              pfValid,
  input logic              pfReady,
  input logic [ADDR_W-1:0] pfAddr,
  input logic [CONF_W-1:0] pfConf
);

  // R8: a stalled request is held unchanged
  assert_hold_stalled_R8: assert property (@(posedge clk) disable iff (!rstN)
    (pfValid && !pfReady) |=> (pfValid && $stable(pfAddr) && $stable(pfConf)));

  // R10: accepted request with no new access retires
  assert_retire_after_accept_R10: assert property (@(posedge clk) disable iff (!rstN)
    (pfValid && pfReady && !accValid) |=> !pfValid);

  // R3: a new request only follows an access
  assert_issue_needs_access_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pfValid) |-> $past(accValid));

  // R4: an issued request always carries a raised confidence
  assert_conf_nonzero_R4: assert property (@(posedge clk) disable iff (!rstN)
    pfValid |-> (pfConf != '0));

endmodule

bind stride_pf stride_pf_chk #(
  .ADDR_W (ADDR_W),
  .CONF_W (CONF_W)
) u_stride_pf_chk (
  .clk      (clk),
  .rstN     (rstN),
  .accValid (accValid),
  .pfValid  (pfValid),
  .pfReady  (pfReady),
  .pfAddr   (pfAddr),
  .pfConf   (pfConf)
);

// File: tb/test_stride_pf.sv
module test_stride_pf;

  localparam int PC_W   = 16;
  localparam int ADDR_W = 16;
  localparam int IDX_W  = 4;
  localparam int PC_LSB = 2;
  localparam int CONF_W = 2;

  logic              clk = 1'b0;
  logic              rstN;
  logic              accValid;
  logic [PC_W-1:0]   accPc;
  logic [ADDR_W-1:0] accAddr;
  logic              pfValid;
  logic              pfReady;
  logic [ADDR_W-1:0] pfAddr;
  logic [CONF_W-1:0] pfConf;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  stride_pf #(
    .PC_W(PC_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .PC_LSB(PC_LSB), .CONF_W(CONF_W)
  ) i_stride_pf (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accPc(accPc), .accAddr(accAddr),
    .pfValid(pfValid), .pfReady(pfReady), .pfAddr(pfAddr), .pfConf(pfConf)
  );

  // Drive one access at a falling edge; returns at the next falling edge
  task automatic doAccess(input logic [PC_W-1:0] pc, input logic [ADDR_W-1:0] addr);
    accValid = 1'b1;
    accPc    = pc;
    accAddr  = addr;
    @(negedge clk);
    accValid = 1'b0;
  endtask

  task automatic expectNone(input string req);
    checks++;
    if (pfValid !== 1'b0) begin
      errors++;
      $display("FAIL %s pfValid actual %b expected 0", req, pfValid);
    end
  endtask

  task automatic expectPf(input string req, input logic [ADDR_W-1:0] addr,
                          input logic [CONF_W-1:0] conf);
    checks++;
    if (pfValid !== 1'b1 || pfAddr !== addr || pfConf !== conf) begin
      errors++;
      $display("FAIL %s actual v=%b a=%h c=%0d expected v=1 a=%h c=%0d",
               req, pfValid, pfAddr, pfConf, addr, conf);
    end
  endtask

  task automatic testReset();
    expectNone("R10 reset");
  endtask

  // R3 R4: positive stride of 16, confidence saturation
  task automatic testPositive();
    doAccess(16'h0100, 16'h1000); expectNone("R2 first");
    doAccess(16'h0100, 16'h1010); expectNone("R5 first stride");
    doAccess(16'h0100, 16'h1020); expectPf("R3 match", 16'h1030, 2'd1);
    doAccess(16'h0100, 16'h1030); expectPf("R4 conf2", 16'h1040, 2'd2);
    doAccess(16'h0100, 16'h1040); expectPf("R4 conf3", 16'h1050, 2'd3);
    doAccess(16'h0100, 16'h1050); expectPf("R4 saturate", 16'h1060, 2'd3);
  endtask

  // R5: mismatch lowers confidence and records the new stride
  task automatic testMismatch();
    doAccess(16'h0100, 16'h1058); expectNone("R5 mismatch");
    doAccess(16'h0100, 16'h1060); expectPf("R5 new stride", 16'h1068, 2'd3);
  endtask

  // R6: stride of -1
  task automatic testNegative();
    doAccess(16'h0104, 16'h2000); expectNone("R6 first");
    doAccess(16'h0104, 16'h1FFF); expectNone("R6 second");
    doAccess(16'h0104, 16'h1FFE); expectPf("R6 down", 16'h1FFD, 2'd1);
    doAccess(16'h0104, 16'h1FFD); expectPf("R6 down2", 16'h1FFC, 2'd2);
  endtask

  // R7: three interleaved instructions in entries 0,1,2
  task automatic testInterleaved();
    for (int i = 0; i < 4; i++) begin
      doAccess(16'h0200, 16'h3000 + 16'(4 * i));
      if (i >= 2) expectPf("R7 A", 16'h3000 + 16'(4 * (i + 1)), 2'(i - 1));
      else        expectNone("R7 A train");
      doAccess(16'h0204, 16'h5000 + 16'(8 * i));
      if (i >= 2) expectPf("R7 B", 16'h5000 + 16'(8 * (i + 1)), 2'(i - 1));
      else        expectNone("R7 B train");
      doAccess(16'h0208, 16'h7000 - 16'(32 * i));
      if (i >= 2) expectPf("R7 C", 16'h7000 - 16'(32 * (i + 1)), 2'(i - 1));
      else        expectNone("R7 C train");
    end
  endtask

  // R1 R2: 0x10C and 0x14C share entry 3 with different tags
  task automatic testAlias();
    doAccess(16'h010C, 16'h4000);
    doAccess(16'h010C, 16'h4004);
    doAccess(16'h010C, 16'h4008); expectPf("R1 trained", 16'h400C, 2'd1);
    doAccess(16'h014C, 16'h6000); expectNone("R2 alias alloc");
    doAccess(16'h010C, 16'h400C); expectNone("R2 reinit");
    doAccess(16'h010C, 16'h4010); expectNone("R2 relearn");
    doAccess(16'h010C, 16'h4014); expectPf("R1 retrained", 16'h4018, 2'd1);
  endtask

  // R9: repeated address never prefetches
  task automatic testZeroStride();
    for (int i = 0; i < 4; i++) begin
      doAccess(16'h0110, 16'h9000); expectNone("R9 zero stride");
    end
  endtask

  // R8 R10: backpressure and retirement
  task automatic testBackpressure();
    doAccess(16'h0114, 16'hA000);
    doAccess(16'h0114, 16'hA010);
    pfReady = 1'b0;
    doAccess(16'h0114, 16'hA020); expectPf("R8 first", 16'hA030, 2'd1);
    doAccess(16'h0114, 16'hA030); expectPf("R8 dropped", 16'hA030, 2'd1);
    @(negedge clk);               expectPf("R8 held", 16'hA030, 2'd1);
    pfReady = 1'b1;
    @(negedge clk);               expectNone("R10 retire");
    doAccess(16'h0114, 16'hA040); expectPf("R8 training kept", 16'hA050, 2'd3);
    @(negedge clk);               expectNone("R10 idle");
  endtask

  initial begin
    rstN = 1'b0; accValid = 1'b0; accPc = '0; accAddr = '0; pfReady = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPositive();
    testMismatch();
    testNegative();
    testInterleaved();
    testAlias();
    testZeroStride();
    testBackpressure();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual hung expected done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule